// File: doc/BRIEF.md
# Printer Strobe and Port A Decoder

This block sits beside the sound generator's register file and watches every write to its general-purpose I/O port A. From the stream of port-A bytes it recovers a parallel-printer handshake. When the strobe bit of port A goes from high to low between two consecutive writes, and printing is enabled, the block emits a one-cycle transfer that carries the current port-B byte. It also emits a busy-interrupt request, plus an acknowledge-interrupt request when the alternate machine variant is selected.

The same writes also drive two drive-select indicators, which are held between writes. On the alternate variant they additionally produce two reset-request pulses, one for a signal processor and one for a disk interface.

The port-A write is a valid-qualified stream with no ready: the block accepts a byte on every cycle that `pa_wr_valid` is high and never stalls the writer. The transfer output is likewise valid-only. The consumer must take every `xfer_valid` pulse in the cycle it appears, because nothing is held back or retried.

Top module: `prn_port_ctrl`

## Requirements
- R1: After reset all outputs are 0 and the stored previous strobe is 0, so a first write with bit 5 = 0 causes no transfer.
- R2: A write with bit 5 = 0 whose preceding port-A write had bit 5 = 1, made while `print_en` = 1, gives `xfer_valid` = 1 in the cycle after the write, with `xfer_data` equal to `pb_data` sampled at the write.
- R3: A write that does not take bit 5 from 1 to 0 (0 then 0, 1 then 1, or 0 then 1) gives no transfer.
- R4: While `print_en` = 0, no transfer is issued. The stored strobe is still updated, so a bit-5 = 1 write made while disabled arms a transfer for the next enabled bit-5 = 0 write.
- R5: `busy_irq` pulses in the same cycle as every transfer. `ack_irq` pulses with it only when `alt_variant` = 1 at the write.
- R6: `drv_a_sel` takes the inverse of written bit 1 and `drv_b_sel` takes the inverse of written bit 2, one cycle after the write. Both hold until the next port-A write.
- R7: With `alt_variant` = 1, a write with bit 4 = 1 pulses `dsp_rst_req` and a write with bit 7 = 1 pulses `disk_rst_req`. With `alt_variant` = 0 neither pulses.
- R8: `xfer_valid`, `busy_irq`, `ack_irq`, `dsp_rst_req` and `disk_rst_req` are high for one cycle per causing write and low in cycles that follow no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pa_wr_valid | input | 1 | Port-A byte present this cycle |
| pa_wr_data | input | 8 | Port-A byte being written |
| pb_data | input | 8 | Current port-B byte |
| print_en | input | 1 | Printing enabled |
| alt_variant | input | 1 | Alternate machine variant selected |
| xfer_valid | output | 1 | One-cycle printer transfer |
| xfer_data | output | 8 | Byte transferred to the printer |
| busy_irq | output | 1 | Busy interrupt request pulse |
| ack_irq | output | 1 | Acknowledge interrupt request pulse (alternate variant) |
| drv_a_sel | output | 1 | Drive A selected indicator |
| drv_b_sel | output | 1 | Drive B selected indicator |
| dsp_rst_req | output | 1 | Signal-processor reset request pulse |
| disk_rst_req | output | 1 | Disk-interface reset request pulse |

## Verification
The assertions assume that `rst_n` is held low for at least one clock before any write, and that the inputs do not change in the middle of a cycle. They also assume that `alt_variant` and `print_en` are only examined in cycles where `pa_wr_valid` is high. The bench respects these conditions by holding reset for several cycles and by changing every input on the falling edge. It raises `pa_wr_valid` for exactly one cycle per write and leaves gaps between writes, so that the single-cycle pulses and the holding of the indicators can both be seen.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned STB_POS   = 5;
  localparam int unsigned DRVA_POS  = 1;
  localparam int unsigned DRVB_POS  = 2;
  localparam int unsigned DSP_POS   = 4;
  localparam int unsigned DISK_POS  = 7;

  typedef struct packed {
    logic busy;
    logic ack;
  } irq_pair_t;
endpackage

// File: rtl/prn_strobe_edge.sv
module prn_strobe_edge #(
  parameter int unsigned DW      = 8,
  parameter int unsigned STB_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] pb_byte,
  input  logic          enable,
  output logic          fire,
  output logic [DW-1:0] fire_data
);
  logic prev_stb;
  logic fall_now;

  assign fall_now = wr_valid && enable && prev_stb && !wr_data[STB_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_stb  <= 1'b0;
      fire      <= 1'b0;
      fire_data <= '0;
    end else begin
      fire <= fall_now;
      if (wr_valid) prev_stb <= wr_data[STB_BIT];
      if (fall_now) fire_data <= pb_byte;
    end
  end

  assert_fire_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  assert_fire_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(wr_valid) && $past(enable));
  assert_fire_low_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !$past(wr_data[STB_BIT]));
  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !fire);
endmodule

// File: rtl/prn_irq_gen.sv
module prn_irq_gen
  import prn_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_valid,
  input  logic      alt,
  input  logic      fire,
  output irq_pair_t irq
);
  logic alt_at_write;

  always_ff @(posedge clk) begin
    if (!rst_n) alt_at_write <= 1'b0;
    else if (wr_valid) alt_at_write <= alt;
  end

  always_comb begin
    irq.busy = fire;
    irq.ack  = fire && alt_at_write;
  end

  assert_ack_implies_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq.ack |-> irq.busy);
endmodule

// File: rtl/prn_port_bits.sv
module prn_port_bits #(
  parameter int unsigned DW       = 8,
  parameter int unsigned DRVA_BIT = 1,
  parameter int unsigned DRVB_BIT = 2,
  parameter int unsigned DSP_BIT  = 4,
  parameter int unsigned DISK_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          alt,
  output logic [1:0]    drv_sel,
  output logic          dsp_req,
  output logic          disk_req
);
  localparam int unsigned NDRV = 2;
  localparam int unsigned DRV_POS [NDRV] = '{DRVA_BIT, DRVB_BIT};

  for (genvar g = 0; g < NDRV; g++) begin : g_drv
    always_ff @(posedge clk) begin
      if (!rst_n) drv_sel[g] <= 1'b0;
      else if (wr_valid) drv_sel[g] <= ~wr_data[DRV_POS[g]];
    end
    assert_drv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> $stable(drv_sel[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsp_req  <= 1'b0;
      disk_req <= 1'b0;
    end else begin
      dsp_req  <= wr_valid && alt && wr_data[DSP_BIT];
      disk_req <= wr_valid && alt && wr_data[DISK_BIT];
    end
  end

  assert_req_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_req || disk_req) |-> $past(wr_valid));
  assert_req_needs_alt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_req || disk_req) |-> $past(alt));
endmodule

// File: rtl/prn_port_ctrl.sv
module prn_port_ctrl
  import prn_port_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pa_wr_valid,
  input  logic [DW-1:0] pa_wr_data,
  input  logic [DW-1:0] pb_data,
  input  logic          print_en,
  input  logic          alt_variant,
  output logic          xfer_valid,
  output logic [DW-1:0] xfer_data,
  output logic          busy_irq,
  output logic          ack_irq,
  output logic          drv_a_sel,
  output logic          drv_b_sel,
  output logic          dsp_rst_req,
  output logic          disk_rst_req
);
  irq_pair_t  irq;
  logic [1:0] drv;

  prn_strobe_edge #(.DW(DW), .STB_BIT(STB_POS)) u_edge (
    .clk(clk), .rst_n(rst_n), .wr_valid(pa_wr_valid), .wr_data(pa_wr_data),
    .pb_byte(pb_data), .enable(print_en), .fire(xfer_valid), .fire_data(xfer_data)
  );

  prn_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .wr_valid(pa_wr_valid), .alt(alt_variant),
    .fire(xfer_valid), .irq(irq)
  );

  prn_port_bits #(
    .DW(DW), .DRVA_BIT(DRVA_POS), .DRVB_BIT(DRVB_POS),
    .DSP_BIT(DSP_POS), .DISK_BIT(DISK_POS)
  ) u_bits (
    .clk(clk), .rst_n(rst_n), .wr_valid(pa_wr_valid), .wr_data(pa_wr_data),
    .alt(alt_variant), .drv_sel(drv), .dsp_req(dsp_rst_req), .disk_req(disk_rst_req)
  );

  assign busy_irq  = irq.busy;
  assign ack_irq   = irq.ack;
  assign drv_a_sel = drv[0];
  assign drv_b_sel = drv[1];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !xfer_valid && !busy_irq && !drv_a_sel && !drv_b_sel);
endmodule

// File: tb/prn_port_ctrl_tb.sv
module prn_port_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pa_wr_valid;
  logic [7:0] pa_wr_data, pb_data;
  logic       print_en, alt_variant;
  logic       xfer_valid, busy_irq, ack_irq, drv_a_sel, drv_b_sel, dsp_rst_req, disk_rst_req;
  logic [7:0] xfer_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  prn_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pa_wr_valid(pa_wr_valid), .pa_wr_data(pa_wr_data),
    .pb_data(pb_data), .print_en(print_en), .alt_variant(alt_variant),
    .xfer_valid(xfer_valid), .xfer_data(xfer_data), .busy_irq(busy_irq), .ack_irq(ack_irq),
    .drv_a_sel(drv_a_sel), .drv_b_sel(drv_b_sel), .dsp_rst_req(dsp_rst_req),
    .disk_rst_req(disk_rst_req)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one write cycle; on return (falling edge) outputs show the registered result
  task automatic wr(input logic [7:0] d, input logic [7:0] pb, input logic en, input logic alt);
    @(negedge clk);
    pa_wr_valid = 1'b1; pa_wr_data = d; pb_data = pb; print_en = en; alt_variant = alt;
    @(negedge clk);
    pa_wr_valid = 1'b0; pb_data = 8'h00;
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    check(req, "xfer after idle", xfer_valid, 0);
    check(req, "busy after idle", busy_irq, 0);
    check(req, "dsp after idle", dsp_rst_req, 0);
    check(req, "disk after idle", disk_rst_req, 0);
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0; pa_wr_valid = 1'b0; pa_wr_data = 8'h00; pb_data = 8'h00;
    print_en = 1'b1; alt_variant = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "xfer_valid", xfer_valid, 0);
    check("R1", "busy_irq", busy_irq, 0);
    check("R1", "ack_irq", ack_irq, 0);
    check("R1", "drv_a_sel", drv_a_sel, 0);
    check("R1", "drv_b_sel", drv_b_sel, 0);
    rst_n = 1'b1;
    wr(8'h06, 8'h5A, 1'b1, 1'b0); // bit5=0 first write: no transfer
    check("R1", "first low write xfer", xfer_valid, 0);
  endtask

  task automatic t_transfer_r2();
    wr(8'h26, 8'h11, 1'b1, 1'b0);
    check("R2", "rise no xfer", xfer_valid, 0);
    wr(8'h06, 8'hC3, 1'b1, 1'b0);
    check("R2", "fall xfer", xfer_valid, 1);
    check("R2", "xfer data", xfer_data, 8'hC3);
    idle_check("R8");
  endtask

  task automatic t_no_edge_r3();
    wr(8'h06, 8'h01, 1'b1, 1'b0);
    check("R3", "0 then 0", xfer_valid, 0);
    wr(8'h26, 8'h02, 1'b1, 1'b0);
    check("R3", "0 then 1", xfer_valid, 0);
    wr(8'hA6, 8'h03, 1'b1, 1'b0);
    check("R3", "1 then 1", xfer_valid, 0);
    wr(8'h06, 8'h04, 1'b1, 1'b0); // restore low
  endtask

  task automatic t_disabled_r4();
    wr(8'h26, 8'h00, 1'b1, 1'b0);
    wr(8'h06, 8'h77, 1'b0, 1'b0);
    check("R4", "disabled fall", xfer_valid, 0);
    check("R4", "disabled busy", busy_irq, 0);
    wr(8'h06, 8'h78, 1'b1, 1'b0); // prev now 0: nothing
    check("R4", "prev tracked while off", xfer_valid, 0);
    wr(8'h26, 8'h00, 1'b0, 1'b0); // arm while off
    wr(8'h06, 8'h9E, 1'b1, 1'b0);
    check("R4", "armed while off", xfer_valid, 1);
    check("R4", "armed data", xfer_data, 8'h9E);
  endtask

  task automatic t_irq_r5();
    wr(8'h26, 8'h00, 1'b1, 1'b0);
    wr(8'h06, 8'h12, 1'b1, 1'b0);
    check("R5", "busy base", busy_irq, 1);
    check("R5", "ack base", ack_irq, 0);
    wr(8'h26, 8'h00, 1'b1, 1'b1);
    check("R5", "busy without xfer", busy_irq, 0);
    wr(8'h06, 8'h34, 1'b1, 1'b1);
    check("R5", "busy alt", busy_irq, 1);
    check("R5", "ack alt", ack_irq, 1);
    @(negedge clk);
    check("R8", "ack one cycle", ack_irq, 0);
  endtask

  task automatic t_drive_r6();
    wr(8'h04, 8'h00, 1'b1, 1'b0); // bit1=0, bit2=1
    check("R6", "drv_a bit1 low", drv_a_sel, 1);
    check("R6", "drv_b bit2 high", drv_b_sel, 0);
    repeat (3) @(negedge clk);
    check("R6", "drv_a hold", drv_a_sel, 1);
    check("R6", "drv_b hold", drv_b_sel, 0);
    wr(8'h02, 8'h00, 1'b1, 1'b0); // bit1=1, bit2=0
    check("R6", "drv_a bit1 high", drv_a_sel, 0);
    check("R6", "drv_b bit2 low", drv_b_sel, 1);
  endtask

  task automatic t_reqs_r7();
    wr(8'h90, 8'h00, 1'b1, 1'b0);
    check("R7", "dsp base variant", dsp_rst_req, 0);
    check("R7", "disk base variant", disk_rst_req, 0);
    wr(8'h10, 8'h00, 1'b1, 1'b1);
    check("R7", "dsp alt bit4", dsp_rst_req, 1);
    check("R7", "disk alt bit4 only", disk_rst_req, 0);
    wr(8'h80, 8'h00, 1'b1, 1'b1);
    check("R7", "dsp alt bit7 only", dsp_rst_req, 0);
    check("R7", "disk alt bit7", disk_rst_req, 1);
    idle_check("R8");
  endtask

  initial begin
    t_reset_r1();
    t_transfer_r2();
    t_no_edge_r3();
    t_disabled_r4();
    t_irq_r5();
    t_drive_r6();
    t_reqs_r7();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule